// File: doc/BRIEF.md
# Sample Buffer with DMA Request and Interrupt Status

This block sits between an analog-to-digital converter and the host bus. It queues 16-bit two's complement samples from the converter in a first-word-fall-through buffer, hands the oldest one to a host read port, and can drain the queue through a DMA handshake instead. A read-only status word summarises buffer occupancy, sticky error and end-of-acquisition conditions, DMA terminal count and pending interrupt. A control register selects DMA enable, single-word or demand-mode requests, and which conditions raise the interrupt.

The DMA side is a three-state sequencer. In IDLE no request is driven. It moves to REQ once DMA is enabled, the buffer holds data and terminal count has not been reached. In REQ the request is driven while those conditions still hold. An accepted acknowledge in single-word mode takes the GAP transition, and GAP returns to IDLE in the next cycle, so that every word has its own request. In demand mode an acknowledge keeps the sequencer in REQ. If any condition drops while in REQ, the sequencer goes back to IDLE. Every accepted acknowledge pops one word and counts down a transfer counter that software loads. When that counter reaches zero, the terminal-count flag is raised.

Top module: `smp_fifo_dma`

## Requirements
- R1: Samples leave in arrival order. `rd_data` shows the oldest stored word unchanged, and shows zero when the buffer is empty. `rd_pop` on an empty buffer has no effect. A push and a pop in the same cycle are both accepted.
- R2: Status bit 0 is 1 exactly when the buffer holds at least one word.
- R3: A push while the buffer holds DEPTH words and no pop happens in that cycle discards the sample. It also sets status bit 3, which stays set until a buffer clear.
- R4: `fifo_clr` empties the buffer and clears status bits 0, 3 and 4. It wins over a push, a pop or `acq_done` in the same cycle.
- R5: An `acq_done` pulse sets status bit 4, which stays set until a buffer clear.
- R6: With control bit 3 set and control bit 12 clear, `dma_req` is low in the cycle after each accepted acknowledge.
- R7: With control bits 3 and 12 set, `dma_req` stays high through back-to-back acknowledges while the buffer is not empty. It drops once the buffer empties.
- R8: Each acknowledge accepted while `dma_req` is high pops one word and decrements the transfer counter, which is loaded by `xfer_load`. The decrement from 1 to 0 sets status bit 7. While bit 7 is set, `dma_req` stays low.
- R9: `tc_clr` clears status bit 7 and the terminal-count interrupt. It wins over a terminal-count event in the same cycle.
- R10: `irq`, mirrored in status bit 6, is high when any of these holds:
  - control bit 8 is set and, if control bit 9 is set, the buffer holds at least DEPTH/2 words, otherwise the buffer is not empty;
  - control bit 8 is set and status bit 4 is set;
  - control bit 11 is set and status bit 7 is set.
- R11: After reset the control register is zero, status is 0x0000, and `dma_req`, `irq` and `rd_data` are low. Status bits other than 0, 3, 4, 6 and 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | DATA_W | Converter sample, two's complement |
| acq_done | input | 1 | End-of-acquisition pulse |
| rd_pop | input | 1 | Host read: remove the oldest word |
| rd_data | output | DATA_W | Oldest stored word, zero when empty |
| fifo_clr | input | 1 | Buffer clear strobe |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write value |
| xfer_load | input | 1 | Transfer counter load strobe |
| xfer_count | input | CNT_W | Transfer counter load value |
| tc_clr | input | 1 | Terminal-count clear strobe |
| dma_ack | input | 1 | DMA acknowledge, one word per cycle |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |
| status | output | 16 | Status word |

## Verification
The assertions assume that `dma_ack` is raised only while `dma_req` is high and never in the same cycle as `rd_pop`. Under these assumptions each cycle has a single pop source, and an acknowledge always refers to a word that is present. The bench keeps to this by sampling `dma_req` before it drives an acknowledge, and it never drives the host read port during DMA sequences. Clear strobes are kept apart from the events they compete with, except in the one case that checks clear priority on purpose.

// File: rtl/smp_fifo_pkg.sv
package smp_fifo_pkg;
    // Status word bit positions (decoded by host software)
    localparam int ST_NE   = 0;
    localparam int ST_OVF  = 3;
    localparam int ST_EOA  = 4;
    localparam int ST_IRQ  = 6;
    localparam int ST_TC   = 7;

    // Control word bit positions
    localparam int CT_DMA_EN  = 3;
    localparam int CT_FIFO_IE = 8;
    localparam int CT_HALF    = 9;
    localparam int CT_TC_IE   = 11;
    localparam int CT_DEMAND  = 12;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        DM_IDLE = 2'd0,
        DM_REQ  = 2'd1,
        DM_GAP  = 2'd2
    } dma_state_e;

    typedef struct packed {
        logic dma_en;
        logic fifo_ie;
        logic half_sel;
        logic tc_ie;
        logic demand;
    } ctrl_t;
endpackage

// File: rtl/smp_fifo_store.sv
module smp_fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              half_full,
    output logic              overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_N = CW'(DEPTH / 2);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     fill_q;
    logic              ovf_q;
    logic              full, pop_ok, push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full      = (fill_q == FULL_N);
    assign not_empty = (fill_q != '0);
    assign half_full = (fill_q >= HALF_N);
    assign pop_ok    = pop && not_empty;
    assign push_ok   = push && (!full || pop_ok);
    assign overflow  = ovf_q;
    assign head      = not_empty ? mem_q[rd_ptr_q] : '0;

    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
            ovf_q    <= 1'b0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (pop_ok) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
            if (push && !push_ok) begin
                ovf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/smp_xfer_cnt.sv
module smp_xfer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             tc_clr,
    output logic             tc_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             tc_q;
    logic             hit;

    assign hit     = dec && !load && (cnt_q == ONE);
    assign tc_flag = tc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (tc_clr) begin
            tc_q <= 1'b0;
        end else if (hit) begin
            tc_q <= 1'b1;
        end
    end
endmodule

// File: rtl/smp_dma_seq.sv
module smp_dma_seq
    import smp_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic demand,
    input  logic not_empty,
    input  logic tc_flag,
    input  logic dma_ack,
    output logic dma_req,
    output logic ack_ok
);
    dma_state_e state_q, state_d;
    logic       go;

    assign go = dma_en && not_empty && !tc_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DM_IDLE: begin
                if (go) state_d = DM_REQ;
            end
            DM_REQ: begin
                if (!go)           state_d = DM_IDLE;
                else if (dma_ack)  state_d = demand ? DM_REQ : DM_GAP;
            end
            DM_GAP: begin
                state_d = DM_IDLE;
            end
            default: state_d = DM_IDLE;
        endcase
    end

    always_comb begin
        dma_req = 1'b0;
        unique case (state_q)
            DM_REQ:  dma_req = go;
            DM_IDLE,
            DM_GAP:  dma_req = 1'b0;
            default: dma_req = 1'b0;
        endcase
        ack_ok = dma_req && dma_ack;
    end
endmodule

// File: rtl/smp_fifo_dma.sv
module smp_fifo_dma
    import smp_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              acq_done,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fifo_clr,
    input  logic              ctrl_we,
    input  logic [REG_W-1:0]  ctrl_wdata,
    input  logic              xfer_load,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              tc_clr,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              irq,
    output logic [REG_W-1:0]  status
);
    ctrl_t ctrl_q;
    logic  eoa_q;
    logic  not_empty, half_full, overflow, tc_flag, ack_ok, pop;
    logic  fifo_cond;
    logic  unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata[REG_W-1:CT_DEMAND+1], ctrl_wdata[CT_TC_IE-1],
                                ctrl_wdata[CT_FIFO_IE-1:CT_DMA_EN+1], ctrl_wdata[CT_DMA_EN-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.dma_en   <= ctrl_wdata[CT_DMA_EN];
            ctrl_q.fifo_ie  <= ctrl_wdata[CT_FIFO_IE];
            ctrl_q.half_sel <= ctrl_wdata[CT_HALF];
            ctrl_q.tc_ie    <= ctrl_wdata[CT_TC_IE];
            ctrl_q.demand   <= ctrl_wdata[CT_DEMAND];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoa_q <= 1'b0;
        end else if (fifo_clr) begin
            eoa_q <= 1'b0;
        end else if (acq_done) begin
            eoa_q <= 1'b1;
        end
    end

    assign pop = rd_pop || ack_ok;

    smp_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (smp_valid),
        .push_data (smp_data),
        .pop       (pop),
        .head      (rd_data),
        .not_empty (not_empty),
        .half_full (half_full),
        .overflow  (overflow)
    );

    smp_dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (ctrl_q.dma_en),
        .demand    (ctrl_q.demand),
        .not_empty (not_empty),
        .tc_flag   (tc_flag),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .ack_ok    (ack_ok)
    );

    smp_xfer_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer_load),
        .load_val (xfer_count),
        .dec      (ack_ok),
        .tc_clr   (tc_clr),
        .tc_flag  (tc_flag)
    );

    assign fifo_cond = ctrl_q.half_sel ? half_full : not_empty;
    assign irq = (ctrl_q.fifo_ie && (fifo_cond || eoa_q)) || (ctrl_q.tc_ie && tc_flag);

    always_comb begin
        status         = '0;
        status[ST_NE]  = not_empty;
        status[ST_OVF] = overflow;
        status[ST_EOA] = eoa_q;
        status[ST_IRQ] = irq;
        status[ST_TC]  = tc_flag;
    end
endmodule

// File: rtl/smp_fifo_dma_chk.sv
module smp_fifo_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_clr,
    input logic        tc_clr,
    input logic        rd_pop,
    input logic        dma_ack,
    input logic        dma_req,
    input logic        demand,
    input logic [15:0] status
);
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] && !fifo_clr |=> status[3]);

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (status[4:0] == 5'd0));

    a_r5_eoa_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] && !fifo_clr |=> status[4]);

    a_r6_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && !demand |=> !dma_req);

    a_r8_no_req_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] |-> !dma_req);

    a_r8_ack_only_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |-> dma_req && !rd_pop);

    a_r9_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr |=> !status[7]);

    a_r11_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15:8] == 8'd0) && !status[5] && !status[2] && !status[1]);
endmodule

bind smp_fifo_dma smp_fifo_dma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_clr (fifo_clr),
    .tc_clr   (tc_clr),
    .rd_pop   (rd_pop),
    .dma_ack  (dma_ack),
    .dma_req  (dma_req),
    .demand   (ctrl_q.demand),
    .status   (status)
);

// File: tb/smp_fifo_dma_tb.sv
module smp_fifo_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        acq_done = 1'b0;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_data;
    logic        fifo_clr = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        xfer_load = 1'b0;
    logic [15:0] xfer_count = '0;
    logic        tc_clr = 1'b0;
    logic        dma_ack = 1'b0;
    logic        dma_req;
    logic        irq;
    logic [15:0] status;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_fifo_dma #(.DATA_W(16), .DEPTH(DEPTH), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .acq_done(acq_done), .rd_pop(rd_pop), .rd_data(rd_data), .fifo_clr(fifo_clr),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .xfer_load(xfer_load),
        .xfer_count(xfer_count), .tc_clr(tc_clr), .dma_ack(dma_ack),
        .dma_req(dma_req), .irq(irq), .status(status)
    );

    // op[49:48] (0 idle, 1 push, 2 pop, 3 both), data, expected head, expected status
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd1, 16'h8001, 16'h8001, 16'h0001},
        {2'd1, 16'h7FFF, 16'h8001, 16'h0001},
        {2'd1, 16'h0000, 16'h8001, 16'h0001},
        {2'd2, 16'h0000, 16'h7FFF, 16'h0001},
        {2'd1, 16'hFFFF, 16'h7FFF, 16'h0001},
        {2'd3, 16'h1234, 16'h0000, 16'h0001},
        {2'd2, 16'h0000, 16'hFFFF, 16'h0001},
        {2'd2, 16'h0000, 16'h1234, 16'h0001},
        {2'd2, 16'h0000, 16'h0000, 16'h0000},
        {2'd2, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] v);
        smp_valid = 1'b1; smp_data = v;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 6 && !dma_req; k++) tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 status", status, 32'h0);
        check("R11 req/irq", {dma_req, irq}, 32'h0);
        check("R11 rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        tick();

        // R1/R2: vector walk
        for (int i = 0; i < NVEC; i++) begin
            smp_valid = VEC[i][48];
            rd_pop    = VEC[i][49];
            smp_data  = VEC[i][47:32];
            tick();
            smp_valid = 1'b0; rd_pop = 1'b0;
            check("R1 head", rd_data, VEC[i][31:16]);
            check("R2 status", status, VEC[i][15:0]);
        end

        // R3/R10: fill with half-full interrupt, then overflow
        wr_ctrl(16'h0300);
        for (int i = 0; i < 7; i++) push(16'(i));
        check("R10 below half", status, 32'h0001);
        push(16'd7);
        check("R10 half full irq", {irq, status}, {16'h1, 16'h0041});
        for (int i = 8; i < DEPTH; i++) push(16'(i));
        push(16'h00FF);
        check("R3 overflow set", status, 32'h0049);
        for (int i = 0; i < DEPTH; i++) begin
            check("R3 stored order", rd_data, 32'(i));
            pop();
        end
        check("R3 overflow sticky", status, 32'h0008);

        // R4: clear wins over push
        fifo_clr = 1'b1; smp_valid = 1'b1; smp_data = 16'hAAAA;
        tick();
        fifo_clr = 1'b0; smp_valid = 1'b0;
        check("R4 clear", {rd_data, status}, 32'h0);

        // R5/R10: end of acquisition
        wr_ctrl(16'h0000);
        acq_done = 1'b1; tick(); acq_done = 1'b0;
        check("R5 eoa", status, 32'h0010);
        wr_ctrl(16'h0100);
        check("R10 eoa irq", status, 32'h0050);
        clear();
        check("R4 eoa cleared", status, 32'h0000);
        push(16'h5555);
        check("R10 not-empty irq", {irq, status}, {16'h1, 16'h0041});
        clear();

        // R6/R8/R9: single-word DMA with terminal count
        wr_ctrl(16'h0808);
        xfer_load = 1'b1; xfer_count = 16'd3; tick(); xfer_load = 1'b0;
        push(16'h0A0A); push(16'h0B0B); push(16'h0C0C);
        for (int i = 0; i < 3; i++) begin
            wait_req();
            check("R8 req present", dma_req, 32'h1);
            check("R8 dma word", rd_data, 32'h0A0A + 32'(i) * 32'h0101);
            dma_ack = 1'b1; tick(); dma_ack = 1'b0;
            check("R6 gap after ack", dma_req, 32'h0);
            if (i == 1) check("R8 no tc yet", status, 32'h0001);
        end
        check("R8 tc reached", {irq, status}, {16'h1, 16'h00C0});
        push(16'h0D0D);
        tick(); tick(); tick();
        check("R8 req held off", {dma_req, status}, {16'h0, 16'h00C1});
        wr_ctrl(16'h0800);
        tc_clr = 1'b1; tick(); tc_clr = 1'b0;
        check("R9 tc cleared", {irq, status}, {16'h0, 16'h0001});
        clear();

        // R7: demand mode
        wr_ctrl(16'h1008);
        xfer_load = 1'b1; xfer_count = 16'd10; tick(); xfer_load = 1'b0;
        for (int i = 0; i < 4; i++) push(16'h2000 + 16'(i));
        tick();
        for (int i = 0; i < 4; i++) begin
            check("R7 req held", dma_req, 32'h1);
            check("R7 word", rd_data, 32'h2000 + 32'(i));
            dma_ack = 1'b1; tick(); dma_ack = 1'b0;
        end
        check("R7 drained", {dma_req, status}, {16'h0, 16'h0000});

        summary();
    end
endmodule